// File: doc/BRIEF.md
# Process-Tagged Translation Lookaside Buffer

This block caches recent virtual-to-physical page translations for a processor's memory pipeline. Each slot holds a virtual page number, the identifier of the process that owns the mapping, a physical page number and three attribute bits: writable, user-accessible and dirty. A lookup compares the incoming page number and process identifier against every slot at once. It returns the physical page on a hit, flags a miss otherwise, and raises a protection fault when the access breaks the slot's permissions.

Because every slot carries its owner's identifier, a context switch only changes the identifier presented on the lookup port, and no slots need to be flushed. Refills come from a hardware page-table walker or from software through a single fill port. Two invalidate commands are provided: one clears the whole array, and one clears only the slots owned by one process. When a new translation needs a slot, the block picks it in this order:

1. the slot already holding the same page and process;
2. otherwise the lowest-numbered empty slot;
3. otherwise the least recently used slot.

Top module: `ctx_tlb`

## Requirements
- R1: On a hit, `lk_ppn` equals the physical page stored in the matching slot. Whenever there is no hit, `lk_ppn` is zero.
- R2: A hit requires a valid slot whose page number and process identifier both equal the lookup's. `lk_miss` is high when `lk_valid` is high and no slot matches. When `lk_valid` is low, both `lk_hit` and `lk_miss` are low.
- R3: The lookup is combinational. A translation written through the fill port can be seen on the lookup outputs from the cycle that follows the fill's clock edge.
- R4: A fill lands in one of three places, checked in this order: the valid slot already holding the same page and process (which is overwritten); otherwise the lowest-indexed invalid slot; otherwise the valid slot whose last use is oldest. A use is either a fill or a lookup hit. When a fill and a lookup happen in the same cycle, only the fill counts as a use.
- R5: A write hit (`lk_write`=1) to a slot whose writable bit is 0 raises `lk_fault`.
- R6: A user-mode hit (`lk_user`=1) to a slot whose user-access bit is 0 raises `lk_fault`. In kernel mode the user-access bit has no effect. `lk_fault` is never high without a hit.
- R7: `lk_dirty` is 1 only on a write hit to a slot whose dirty bit is 1. It is 0 for reads and for misses.
- R8: `inv_all` clears every slot in one cycle. A fill presented in the same cycle is discarded.
- R9: `inv_pid_en` clears only the slots whose process identifier equals `inv_pid`. A fill in the same cycle is still written, and its slot is chosen from the state before the invalidation.
- R10: After reset no slot is valid, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_pid | input | PID_W | Process identifier of the requester |
| lk_write | input | 1 | 1 for a store, 0 for a load |
| lk_user | input | 1 | 1 for user mode, 0 for kernel mode |
| lk_hit | output | 1 | A matching translation was found |
| lk_miss | output | 1 | A lookup found no translation |
| lk_ppn | output | PPN_W | Translated physical page (zero without a hit) |
| lk_fault | output | 1 | Permission violation on a hit |
| lk_dirty | output | 1 | Write hit on a slot already marked dirty |
| fill_valid | input | 1 | Write a translation this cycle |
| fill_vpn | input | VPN_W | Page number of the new translation |
| fill_pid | input | PID_W | Owning process of the new translation |
| fill_ppn | input | PPN_W | Physical page of the new translation |
| fill_writable | input | 1 | Writable bit of the new translation |
| fill_user_ok | input | 1 | User-access bit of the new translation |
| fill_dirty | input | 1 | Dirty bit of the new translation |
| inv_all | input | 1 | Clear every slot |
| inv_pid_en | input | 1 | Clear the slots owned by `inv_pid` |
| inv_pid | input | PID_W | Process whose slots are cleared |

## Verification
The assertions assume that the slot array never holds two valid copies of the same page and process pair. The design upholds this by routing a repeated fill onto the existing slot, so the stimulus may freely repeat fills, and the random phase deliberately draws page numbers from a narrow range to force such repeats. The recency ages are assumed to stay a permutation of the slot indices from reset onward. The bench drives only one fill per cycle. It never sets a lookup alongside a fill unless the case under test needs it, which keeps the ordering of uses well defined for its reference model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef struct packed {
    logic writable;
    logic user_ok;
    logic dirty;
  } pte_flags_t;

  // Access violates the page attributes.
  function automatic logic perm_fault(pte_flags_t f, logic is_write, logic is_user);
    return (is_write && !f.writable) || (is_user && !f.user_ok);
  endfunction

  // Write access to a page that is already modified.
  function automatic logic dirty_report(pte_flags_t f, logic is_write);
    return is_write && f.dirty;
  endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N     = 32,
  parameter int VPN_W = 20,
  parameter int PID_W = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     valid,
  input  logic [VPN_W-1:0] vpn_tab [N],
  input  logic [PID_W-1:0] pid_tab [N],
  input  logic [VPN_W-1:0] key_vpn,
  input  logic [PID_W-1:0] key_pid,
  output logic [N-1:0]     match_vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match_vec[i] = valid[i] && (vpn_tab[i] == key_vpn) && (pid_tab[i] == key_pid);
  end

  assign any = |match_vec;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++)
      if (match_vec[i]) idx = IDX_W'(i);
  end

endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int N = 32,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     valid,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] victim_idx
);

  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(N - 1);

  logic [IDX_W-1:0] age_q [N];
  logic [N-1:0]     youngest_vec;
  logic             have_free;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] old_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < N; i++) begin
        if (IDX_W'(i) == touch_idx)          age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    old_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        have_free = 1'b1;
        free_idx  = IDX_W'(i);
      end
      if (age_q[i] == OLDEST) old_idx = IDX_W'(i);
    end
  end

  assign victim_idx = have_free ? free_idx : old_idx;

  for (genvar i = 0; i < N; i++) begin : g_young
    assign youngest_vec[i] = (age_q[i] == '0);
  end

  // Ages remain a permutation: exactly one youngest slot.
  p_one_youngest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(youngest_vec) == 1);

  // A touched slot becomes the youngest on the next cycle.
  p_touch_youngest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> youngest_vec[$past(touch_idx)]);

endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 18,
  parameter int PID_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [PID_W-1:0] lk_pid,
  input  logic             lk_write,
  input  logic             lk_user,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_fault,
  output logic             lk_dirty,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PID_W-1:0] fill_pid,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_writable,
  input  logic             fill_user_ok,
  input  logic             fill_dirty,
  input  logic             inv_all,
  input  logic             inv_pid_en,
  input  logic [PID_W-1:0] inv_pid
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PID_W-1:0]   pid_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  pte_flags_t         flg_q [ENTRIES];

  // Named internal events.
  logic [ENTRIES-1:0] lk_match_vec, fl_match_vec;
  logic               lk_any, fl_any;
  logic [IDX_W-1:0]   lk_idx, fl_idx, victim_idx, fill_idx, touch_idx;
  logic               fill_fire, touch_en;
  pte_flags_t         hit_flags;

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_lk_match (
    .valid(valid_q), .vpn_tab(vpn_q), .pid_tab(pid_q),
    .key_vpn(lk_vpn), .key_pid(lk_pid),
    .match_vec(lk_match_vec), .any(lk_any), .idx(lk_idx)
  );

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_fl_match (
    .valid(valid_q), .vpn_tab(vpn_q), .pid_tab(pid_q),
    .key_vpn(fill_vpn), .key_pid(fill_pid),
    .match_vec(fl_match_vec), .any(fl_any), .idx(fl_idx)
  );

  tlb_lru #(.N(ENTRIES)) u_lru (
    .clk(clk), .rst_n(rst_n), .valid(valid_q),
    .touch_en(touch_en), .touch_idx(touch_idx), .victim_idx(victim_idx)
  );

  assign fill_fire = fill_valid && !inv_all;
  assign fill_idx  = fl_any ? fl_idx : victim_idx;
  assign touch_en  = fill_fire || lk_hit;
  assign touch_idx = fill_fire ? fill_idx : lk_idx;

  // Lookup outputs.
  assign hit_flags = flg_q[lk_idx];
  assign lk_hit    = lk_valid && lk_any;
  assign lk_miss   = lk_valid && !lk_any;
  assign lk_ppn    = lk_hit ? ppn_q[lk_idx] : '0;
  assign lk_fault  = lk_hit && perm_fault(hit_flags, lk_write, lk_user);
  assign lk_dirty  = lk_hit && dirty_report(hit_flags, lk_write);

  // Valid bits: global clear, then fill, then per-process clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (inv_all)                                       valid_q[i] <= 1'b0;
        else if (fill_fire && fill_idx == IDX_W'(i))       valid_q[i] <= 1'b1;
        else if (inv_pid_en && pid_q[i] == inv_pid)        valid_q[i] <= 1'b0;
      end
    end
  end

  // Translation payload.
  always_ff @(posedge clk) begin
    if (fill_fire) begin
      vpn_q[fill_idx] <= fill_vpn;
      pid_q[fill_idx] <= fill_pid;
      ppn_q[fill_idx] <= fill_ppn;
      flg_q[fill_idx] <= '{writable: fill_writable, user_ok: fill_user_ok, dirty: fill_dirty};
    end
  end

  p_hit_xor_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (lk_hit ^ lk_miss));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(lk_hit || lk_miss));

  p_single_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match_vec));

  p_fault_on_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_hit);

  p_ppn_zero_on_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_ppn == '0));

  p_dirty_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_dirty |-> (lk_hit && lk_write));

  p_fill_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire |=> valid_q[$past(fill_idx)]);

  p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (valid_q == '0));

endmodule

// File: tb/tb_ctx_tlb.sv
module tb_ctx_tlb;

  localparam int E = 4, V = 6, P = 5, D = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0, lk_write = 0, lk_user = 0;
  logic [V-1:0] lk_vpn = '0;
  logic [D-1:0] lk_pid = '0;
  logic lk_hit, lk_miss, lk_fault, lk_dirty;
  logic [P-1:0] lk_ppn;
  logic fill_valid = 0, fill_writable = 0, fill_user_ok = 0, fill_dirty = 0;
  logic [V-1:0] fill_vpn = '0;
  logic [D-1:0] fill_pid = '0;
  logic [P-1:0] fill_ppn = '0;
  logic inv_all = 0, inv_pid_en = 0;
  logic [D-1:0] inv_pid = '0;

  ctx_tlb #(.ENTRIES(E), .VPN_W(V), .PPN_W(P), .PID_W(D)) dut (.*);

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0, fails = 0, now = 0;
  bit done = 0;

  // Reference model: slots with a last-use stamp.
  bit m_v [E]; int m_vpn [E]; int m_pid [E]; int m_ppn [E];
  bit m_w [E]; bit m_u [E]; bit m_d [E]; int m_stamp [E];

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int m_find(int vpn, int pid);
    for (int i = 0; i < E; i++)
      if (m_v[i] && m_vpn[i] == vpn && m_pid[i] == pid) return i;
    return -1;
  endfunction

  function automatic int m_slot(int vpn, int pid);
    int s, best;
    s = m_find(vpn, pid);
    if (s >= 0) return s;
    for (int i = 0; i < E; i++) if (!m_v[i]) return i;
    best = 0;
    for (int i = 1; i < E; i++) if (m_stamp[i] < m_stamp[best]) best = i;
    return best;
  endfunction

  task automatic idle();
    lk_valid = 0; fill_valid = 0; inv_all = 0; inv_pid_en = 0;
  endtask

  task automatic m_write(int s, int vpn, int pid, int ppn, bit w, bit u, bit d);
    m_v[s] = 1; m_vpn[s] = vpn; m_pid[s] = pid; m_ppn[s] = ppn;
    m_w[s] = w; m_u[s] = u; m_d[s] = d; m_stamp[s] = ++now;
  endtask

  task automatic do_fill(int vpn, int pid, int ppn, bit w, bit u, bit d);
    int s;
    @(negedge clk); idle();
    fill_valid = 1; fill_vpn = V'(vpn); fill_pid = D'(pid); fill_ppn = P'(ppn);
    fill_writable = w; fill_user_ok = u; fill_dirty = d;
    s = m_slot(vpn, pid);
    m_write(s, vpn, pid, ppn, w, u, d);  // R4 slot choice
    @(posedge clk);
  endtask

  // Invalidate, optionally with a fill in the same cycle (R8, R9).
  task automatic do_inv(bit all, bit pen, int pid, bit with_fill, int fvpn, int fpid, int fppn);
    int s;
    @(negedge clk); idle();
    inv_all = all; inv_pid_en = pen; inv_pid = D'(pid);
    fill_valid = with_fill; fill_vpn = V'(fvpn); fill_pid = D'(fpid); fill_ppn = P'(fppn);
    fill_writable = 1; fill_user_ok = 1; fill_dirty = 0;
    if (all) begin
      for (int i = 0; i < E; i++) m_v[i] = 0;
    end else begin
      s = with_fill ? m_slot(fvpn, fpid) : -1;
      for (int i = 0; i < E; i++) if (pen && m_pid[i] == pid && i != s) m_v[i] = 0;
      if (with_fill) m_write(s, fvpn, fpid, fppn, 1, 1, 0);
    end
    @(posedge clk);
  endtask

  task automatic do_look(int vpn, int pid, bit wr, bit usr);
    int e; bit eh, ef, ed; int ep; string ftag;
    @(negedge clk); idle();
    lk_valid = 1; lk_vpn = V'(vpn); lk_pid = D'(pid); lk_write = wr; lk_user = usr;
    #1;
    e  = m_find(vpn, pid);
    eh = (e >= 0);
    ep = eh ? m_ppn[e] : 0;
    ef = eh && ((wr && !m_w[e]) || (usr && !m_u[e]));
    ed = eh && wr && m_d[e];
    ftag = (eh && wr && !m_w[e]) ? "R5 write to read-only" : "R6 user access";
    chk(lk_hit == eh, "R2 hit", int'(lk_hit), int'(eh));
    chk(lk_miss == !eh, "R2 miss", int'(lk_miss), int'(!eh));
    chk(int'(lk_ppn) == ep, "R1 ppn", int'(lk_ppn), ep);
    chk(lk_fault == ef, ftag, int'(lk_fault), int'(ef));
    chk(lk_dirty == ed, "R7 dirty", int'(lk_dirty), int'(ed));
    if (eh) m_stamp[e] = ++now;
    @(posedge clk);
  endtask

  task automatic sweep();
    for (int v = 0; v < (1 << V); v++)
      for (int p = 0; p < (1 << D); p++)
        for (int m = 0; m < 4; m++)
          do_look(v, p, m[0], m[1]);
  endtask

  initial begin
    for (int i = 0; i < E; i++) begin m_v[i] = 0; m_stamp[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R10: empty after reset; idle port quiet (R2).
    #1 chk(!lk_hit && !lk_miss, "R2 idle port", int'(lk_hit | lk_miss), 0);
    sweep();
    // R3, R5, R6, R7: one slot per attribute mix.
    do_fill(3, 0, 17, 0, 1, 0);
    do_fill(3, 1, 9, 1, 0, 1);
    do_fill(40, 2, 31, 1, 1, 1);
    do_fill(63, 3, 1, 1, 1, 0);
    sweep();
    // R4: refill an existing pair, then evict the oldest slot.
    do_fill(40, 2, 22, 0, 0, 0);
    do_look(3, 1, 0, 0);
    do_look(63, 3, 0, 0);
    do_look(40, 2, 0, 0);
    do_fill(12, 1, 5, 1, 1, 1);
    chk(m_find(3, 0) < 0, "R4 model evicts oldest", m_find(3, 0), -1);
    sweep();
    // R9: per-process clear with a simultaneous fill.
    do_inv(0, 1, 1, 1, 50, 1, 7);
    sweep();
    // R8: global clear discards a simultaneous fill.
    do_inv(1, 0, 0, 1, 8, 0, 8);
    sweep();
    // Random mix with narrow page range to force refills and evictions (R4).
    for (int n = 0; n < 1500; n++) begin
      int k;
      k = $urandom_range(9, 0);
      if (k < 3)
        do_fill($urandom_range(7, 0), $urandom_range(3, 0), $urandom_range(31, 0),
                1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
      else if (k == 3)
        do_inv(0, 1, $urandom_range(3, 0), 1'($urandom_range(1, 0)),
               $urandom_range(7, 0), $urandom_range(3, 0), $urandom_range(31, 0));
      else
        do_look($urandom_range(7, 0), $urandom_range(3, 0),
                1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
    end
    sweep();
    @(negedge clk); idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule